// File: doc/BRIEF.md
# Single-Precision Result Rounder

This block is the last stage of a floating-point datapath. An arithmetic unit hands it an unrounded result: a sign, a biased exponent held in two extra bits so it can go below one or above the largest finite exponent, a 24-bit significand with its leading one at the top bit, and three bits below it (guard, round, sticky). It also gets markers for results that were settled early: invalid operation, NaN, division by zero, infinity and zero. The block rounds the value to a packed 32-bit binary32 word and reports five exception flags. The result appears one clock after the input is presented.

The rounding mode comes from a 3-bit instruction field. One code in that field asks for the mode held in the rounding-mode control register instead; the block gets that register's value on a separate input. Values at or below the smallest normal exponent are shifted into the subnormal range before rounding. Results that round past the largest finite value saturate or go to infinity, depending on the mode and the sign.

Top module: `fpr_round_unit`

## Requirements
- R1: While reset is held, `out_valid`, `out_res` and `out_flags` are zero. Every cycle with `in_valid` high produces exactly one `out_valid` pulse on the following clock. While `in_valid` is low, `out_valid` is low and `out_res` and `out_flags` keep their last values.
- R2: Mode codes are 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity and 100 nearest-away. With G the first discarded bit, S the OR of all bits below it and L the kept least significant bit, the magnitude goes up by one unit in the last place when: G&(S|L) under nearest-even, never under toward zero, G|S for negative values under toward minus infinity, G|S for positive values under toward plus infinity, and G under nearest-away.
- R3: When `rm_i` is 111, `frm_i` supplies the mode, with the same encoding as in R2.
- R4: If the mode in effect is 101, 110 or 111 (the last is only possible through `frm_i`), the result is 0x7FC00000 and only the invalid flag, `out_flags[4]`, is set.
- R5: The inexact flag, `out_flags[0]`, is set when a finite result discards any nonzero bits.
- R6: Overflow occurs when the input exponent is 255 or more, or when rounding carries the exponent to 255. It sets overflow (`out_flags[2]`) together with inexact. The result is infinity under nearest-even and nearest-away, and the largest finite magnitude 0x7F7FFFFF under toward zero. Toward plus infinity gives infinity for positive values and the largest finite magnitude for negative ones; toward minus infinity does the mirror image.
- R7: An input exponent E of 0 or below shifts the significand right by 1-E, with all shifted-out bits going into the sticky bit, and gives an exponent field of 0. A rounding carry out of the fraction raises the exponent field to 1.
- R8: Underflow (`out_flags[1]`) is set only when the result is both inexact and tiny after rounding. The result is tiny when E is 0 or below, except when E is 0, the significand is all ones, and rounding at full precision would carry into the exponent.
- R9: The special markers take priority over the finite path, in this order: invalid (0x7FC00000 and the invalid flag), NaN (0x7FC00000, no flags), division by zero (signed infinity and the divide-by-zero flag, `out_flags[3]`), infinity (signed infinity, no flags), zero (signed zero, no flags).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An unrounded result is present this cycle |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | EXP_W+2 | Biased exponent, two's complement |
| in_sig | input | FRAC_W+1 | Significand, leading one at the top bit |
| in_grd | input | 1 | Guard bit below the significand |
| in_rnd | input | 1 | Round bit below the guard bit |
| in_stk | input | 1 | OR of all lower bits |
| in_nan | input | 1 | Result is a NaN |
| in_inf | input | 1 | Result is an exact infinity |
| in_zero | input | 1 | Result is an exact zero |
| in_invalid | input | 1 | The operation was invalid |
| in_divzero | input | 1 | The operation divided a finite value by zero |
| rm_i | input | 3 | Rounding mode from the instruction |
| frm_i | input | 3 | Stored rounding-mode register value |
| out_valid | output | 1 | Result and flags are new this cycle |
| out_res | output | 1+EXP_W+FRAC_W | Packed rounded result |
| out_flags | output | 5 | Invalid, divide-by-zero, overflow, underflow, inexact (bit 4 down to 0) |

## Verification
The bench builds the block with the default EXP_W of 8 and FRAC_W of 23. With these values, expected words such as the canonical NaN and the largest finite value can be written directly as binary32 constants. The 10-bit exponent input can express both 255, which overflows, and values far below zero. The 26-bit alignment window is small enough that an exponent of -40 reaches the path where every significand bit goes into sticky. The same sizes also make the all-ones significand at exponent 0 reachable, which is the case that tells tininess after rounding apart from tininess before it.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;

    typedef enum logic [2:0] {
        RM_RNE = 3'b000,
        RM_RTZ = 3'b001,
        RM_RDN = 3'b010,
        RM_RUP = 3'b011,
        RM_RMM = 3'b100,
        RM_DYN = 3'b111
    } rmode_e;

    localparam int FLG_W = 5;
    localparam int FL_NV = 4;
    localparam int FL_DZ = 3;
    localparam int FL_OF = 2;
    localparam int FL_UF = 1;
    localparam int FL_NX = 0;

    // Decide whether the kept magnitude moves up by one unit in the last place.
    function automatic logic round_up(input rmode_e mode, input logic sign,
                                      input logic lsb, input logic grd, input logic stk);
        logic up;
        case (mode)
            RM_RNE:  up = grd & (stk | lsb);
            RM_RTZ:  up = 1'b0;
            RM_RDN:  up = sign & (grd | stk);
            RM_RUP:  up = ~sign & (grd | stk);
            RM_RMM:  up = grd;
            default: up = 1'b0;
        endcase
        return up;
    endfunction

endpackage

// File: rtl/fpr_mode_sel.sv
`timescale 1ns/1ps
module fpr_mode_sel
    import fpr_pkg::*;
(
    input  logic [2:0] rm_i,
    input  logic [2:0] frm_i,
    output rmode_e     mode_o,
    output logic       bad_o
);

    logic [2:0] eff;

    always_comb begin
        eff    = (rm_i == RM_DYN) ? frm_i : rm_i;
        bad_o  = (eff > 3'b100);
        mode_o = bad_o ? RM_RNE : rmode_e'(eff);
    end

endmodule

// File: rtl/fpr_denorm.sv
`timescale 1ns/1ps
module fpr_denorm #(
    parameter  int SIG_W    = 24,
    parameter  int EXP_IN_W = 10,
    localparam int EXT_W    = SIG_W + 2,
    localparam int SH_W     = EXP_IN_W + 1
) (
    input  logic signed [EXP_IN_W-1:0] exp_i,
    input  logic [SIG_W-1:0]           sig_i,
    input  logic                       grd_i,
    input  logic                       stk_i,
    output logic [SIG_W-2:0]           frac_o,
    output logic                       grd_o,
    output logic                       stk_o,
    output logic                       tiny_o
);

    logic [EXT_W-1:0] wide;
    logic [SH_W-1:0]  sh_u;
    logic [EXT_W-1:0] lost;
    logic [EXT_W-2:0] shifted;
    logic             sh_big;

    assign wide   = {sig_i, grd_i, stk_i};
    assign tiny_o = exp_i[EXP_IN_W-1] || (exp_i == '0);
    assign sh_u   = SH_W'(1) - {exp_i[EXP_IN_W-1], exp_i};
    assign sh_big = (sh_u >= SH_W'(EXT_W));

    // One bit per aligned position: does it fall off the bottom?
    for (genvar i = 0; i < EXT_W; i++) begin : g_lost
        assign lost[i] = wide[i] & (SH_W'(i) < sh_u);
    end

    always_comb begin
        shifted = (EXT_W-1)'(wide >> sh_u);
        if (!tiny_o) begin
            frac_o = sig_i[SIG_W-2:0];
            grd_o  = grd_i;
            stk_o  = stk_i;
        end else if (sh_big) begin
            frac_o = '0;
            grd_o  = 1'b0;
            stk_o  = |wide;
        end else begin
            frac_o = shifted[EXT_W-2:2];
            grd_o  = shifted[1];
            stk_o  = shifted[0] | (|lost);
        end
    end

endmodule

// File: rtl/fpr_pack_round.sv
`timescale 1ns/1ps
module fpr_pack_round
    import fpr_pkg::*;
#(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int MAG_W  = EXP_W + FRAC_W
) (
    input  logic              sign_i,
    input  rmode_e            mode_i,
    input  logic [EXP_W-1:0]  efield_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              grd_i,
    input  logic              stk_i,
    output logic [MAG_W-1:0]  mag_o,
    output logic              at_max_o,
    output logic              inexact_o
);

    logic inc;

    always_comb begin
        inc       = round_up(mode_i, sign_i, frac_i[0], grd_i, stk_i);
        // A carry out of the fraction lands in the exponent field by itself.
        mag_o     = {efield_i, frac_i} + MAG_W'(inc);
        at_max_o  = &mag_o[MAG_W-1:FRAC_W];
        inexact_o = grd_i | stk_i;
    end

endmodule

// File: rtl/fpr_round_unit.sv
`timescale 1ns/1ps
module fpr_round_unit
    import fpr_pkg::*;
#(
    parameter  int EXP_W    = 8,
    parameter  int FRAC_W   = 23,
    localparam int SIG_W    = FRAC_W + 1,
    localparam int EXP_IN_W = EXP_W + 2,
    localparam int WORD_W   = 1 + EXP_W + FRAC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sign,
    input  logic signed [EXP_IN_W-1:0] in_exp,
    input  logic [SIG_W-1:0]           in_sig,
    input  logic                       in_grd,
    input  logic                       in_rnd,
    input  logic                       in_stk,
    input  logic                       in_nan,
    input  logic                       in_inf,
    input  logic                       in_zero,
    input  logic                       in_invalid,
    input  logic                       in_divzero,
    input  logic [2:0]                 rm_i,
    input  logic [2:0]                 frm_i,
    output logic                       out_valid,
    output logic [WORD_W-1:0]          out_res,
    output logic [FLG_W-1:0]           out_flags
);

    localparam logic [EXP_W-1:0]  EXP_ONES = '1;
    localparam logic [WORD_W-1:0] QNAN     = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-2:0] MAG_INF  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-2:0] MAG_MAX  = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
        logic [FLG_W-1:0]  flg;
    } out_t;

    out_t r_d, r_q;

    rmode_e            mode;
    logic              mode_bad;
    logic [FRAC_W-1:0] d_frac;
    logic              d_grd, d_stk, tiny_pre;
    logic [EXP_W-1:0]  efield;
    logic [WORD_W-2:0] mag;
    logic              at_max, rnd_nx;
    logic              exp_big, full_up, tiny_post, ovf, to_inf;

    fpr_mode_sel u_mode (
        .rm_i   (rm_i),
        .frm_i  (frm_i),
        .mode_o (mode),
        .bad_o  (mode_bad)
    );

    fpr_denorm #(.SIG_W(SIG_W), .EXP_IN_W(EXP_IN_W)) u_denorm (
        .exp_i  (in_exp),
        .sig_i  (in_sig),
        .grd_i  (in_grd),
        .stk_i  (in_rnd | in_stk),
        .frac_o (d_frac),
        .grd_o  (d_grd),
        .stk_o  (d_stk),
        .tiny_o (tiny_pre)
    );

    assign efield = tiny_pre ? '0 : in_exp[EXP_W-1:0];

    fpr_pack_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
        .sign_i    (in_sign),
        .mode_i    (mode),
        .efield_i  (efield),
        .frac_i    (d_frac),
        .grd_i     (d_grd),
        .stk_i     (d_stk),
        .mag_o     (mag),
        .at_max_o  (at_max),
        .inexact_o (rnd_nx)
    );

    always_comb begin
        exp_big   = !in_exp[EXP_IN_W-1] &&
                    (in_exp[EXP_IN_W-2:0] >= (EXP_IN_W-1)'(EXP_ONES));
        // Rounding at full precision, as if the exponent range were unbounded.
        full_up   = round_up(mode, in_sign, 1'b1, in_grd, in_rnd | in_stk);
        tiny_post = tiny_pre && !((in_exp == '0) && (&in_sig) && full_up);
        ovf       = exp_big || at_max;
        case (mode)
            RM_RNE, RM_RMM: to_inf = 1'b1;
            RM_RUP:         to_inf = ~in_sign;
            RM_RDN:         to_inf = in_sign;
            default:        to_inf = 1'b0;
        endcase

        r_d     = r_q;
        r_d.vld = in_valid;
        if (in_valid) begin
            r_d.flg = '0;
            if (mode_bad || in_invalid) begin
                r_d.res        = QNAN;
                r_d.flg[FL_NV] = 1'b1;
            end else if (in_nan) begin
                r_d.res = QNAN;
            end else if (in_divzero) begin
                r_d.res        = {in_sign, MAG_INF};
                r_d.flg[FL_DZ] = 1'b1;
            end else if (in_inf) begin
                r_d.res = {in_sign, MAG_INF};
            end else if (in_zero) begin
                r_d.res = {in_sign, {(WORD_W-1){1'b0}}};
            end else if (ovf) begin
                r_d.res        = {in_sign, to_inf ? MAG_INF : MAG_MAX};
                r_d.flg[FL_OF] = 1'b1;
                r_d.flg[FL_NX] = 1'b1;
            end else begin
                r_d.res        = {in_sign, mag};
                r_d.flg[FL_NX] = rnd_nx;
                r_d.flg[FL_UF] = tiny_post & rnd_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid = r_q.vld;
    assign out_res   = r_q.res;
    assign out_flags = r_q.flg;

endmodule

// File: rtl/fpr_round_unit_chk.sv
`timescale 1ns/1ps
module fpr_round_unit_chk #(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        rm_i,
    input logic [2:0]        frm_i,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_res,
    input logic [4:0]        out_flags
);

    localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_res) && $stable(out_flags)));

    // R3
    dyn_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (rm_i == 3'b111) && frm_i[2] && (frm_i[1] || frm_i[0])) |=> out_flags[4]);

    // R4
    nv_qnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[4]) |-> (out_res == QNAN));

    // R6
    ovf_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[2]) |-> (out_flags[0] && !out_flags[1]));

    // R8
    uf_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[1]) |-> out_flags[0]);

    // R9
    dz_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[3]) |->
        ((out_res[WORD_W-2 -: EXP_W] == '1) && (out_res[FRAC_W-1:0] == '0)));

endmodule

bind fpr_round_unit fpr_round_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .rm_i      (rm_i),
    .frm_i     (frm_i),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_flags (out_flags)
);

// File: tb/fpr_round_unit_bench.sv
`timescale 1ns/1ps
module fpr_round_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [9:0]  in_exp = '0;
    logic [23:0] in_sig = '0;
    logic        in_grd = 1'b0, in_rnd = 1'b0, in_stk = 1'b0;
    logic        in_nan = 1'b0, in_inf = 1'b0, in_zero = 1'b0;
    logic        in_invalid = 1'b0, in_divzero = 1'b0;
    logic [2:0]  rm_i = '0, frm_i = '0;
    logic        out_valid;
    logic [31:0] out_res;
    logic [4:0]  out_flags;

    // special marker vector: {invalid, nan, divzero, inf, zero}
    localparam logic [4:0] SP_NO   = 5'b00000;
    localparam logic [4:0] SP_INV  = 5'b10000;
    localparam logic [4:0] SP_NAN  = 5'b01000;
    localparam logic [4:0] SP_DZ   = 5'b00100;
    localparam logic [4:0] SP_INF  = 5'b00010;
    localparam logic [4:0] SP_ZERO = 5'b00001;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  flg;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    fpr_round_unit u_fpr_round_unit (
        .clk, .rst_n, .in_valid, .in_sign, .in_exp, .in_sig, .in_grd, .in_rnd, .in_stk,
        .in_nan, .in_inf, .in_zero, .in_invalid, .in_divzero, .rm_i, .frm_i,
        .out_valid, .out_res, .out_flags
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic send(input string tag, input logic s, input logic [9:0] e,
                        input logic [23:0] sig, input logic [2:0] grs,
                        input logic [4:0] sp, input logic [2:0] rm, input logic [2:0] frm,
                        input logic [31:0] er, input logic [4:0] ef);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1; in_sign = s; in_exp = e; in_sig = sig;
        {in_grd, in_rnd, in_stk} = grs;
        {in_invalid, in_nan, in_divzero, in_inf, in_zero} = sp;
        rm_i = rm; frm_i = frm;
        it.res = er; it.flg = ef; it.cyc = cyc + 1; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        if (n > 1) repeat (n - 1) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check("R1 unexpected valid", 32'(out_valid), 32'h0);
            end else begin
                exp_t it;
                it = q.pop_front();
                check({it.tag, " latency"}, 32'(cyc), 32'(it.cyc));
                check({it.tag, " result"}, out_res, it.res);
                check({it.tag, " flags"}, 32'(out_flags), 32'(it.flg));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset valid", 32'(out_valid), 32'h0);
        check("R1 reset result", out_res, 32'h0);
        check("R1 reset flags", 32'(out_flags), 32'h0);
        rst_n = 1'b1;

        // R2 modes on normal values
        send("R2 rne exact",    0, 10'd127, 24'h800000, 3'b000, SP_NO, 3'b000, 3'b000, 32'h3F800000, 5'h00);
        send("R2 rne tie even", 0, 10'd127, 24'h800000, 3'b100, SP_NO, 3'b000, 3'b000, 32'h3F800000, 5'h01);
        send("R2 rne tie odd",  0, 10'd127, 24'h800001, 3'b100, SP_NO, 3'b000, 3'b000, 32'h3F800002, 5'h01);
        send("R2 rtz",          0, 10'd127, 24'h800001, 3'b101, SP_NO, 3'b001, 3'b000, 32'h3F800001, 5'h01);
        send("R2 rup pos",      0, 10'd127, 24'h800001, 3'b001, SP_NO, 3'b011, 3'b000, 32'h3F800002, 5'h01);
        send("R2 rdn neg",      1, 10'd127, 24'h800001, 3'b001, SP_NO, 3'b010, 3'b000, 32'hBF800002, 5'h01);
        send("R2 rdn pos",      0, 10'd127, 24'h800001, 3'b001, SP_NO, 3'b010, 3'b000, 32'h3F800001, 5'h01);
        send("R2 rmm tie",      0, 10'd127, 24'h800000, 3'b100, SP_NO, 3'b100, 3'b000, 32'h3F800001, 5'h01);
        // R5 inexact from round bit only
        send("R5 round bit",    0, 10'd127, 24'h800000, 3'b010, SP_NO, 3'b000, 3'b000, 32'h3F800000, 5'h01);
        // R3 dynamic selection
        send("R3 dyn rtz",      0, 10'd127, 24'h800001, 3'b101, SP_NO, 3'b111, 3'b001, 32'h3F800001, 5'h01);
        send("R3 dyn rup",      0, 10'd127, 24'h800001, 3'b001, SP_NO, 3'b111, 3'b011, 32'h3F800002, 5'h01);
        // R4 reserved encodings
        send("R4 rm 101",       0, 10'd127, 24'h800000, 3'b000, SP_NO, 3'b101, 3'b000, 32'h7FC00000, 5'h10);
        send("R4 rm 110",       1, 10'd127, 24'h800000, 3'b000, SP_NO, 3'b110, 3'b000, 32'h7FC00000, 5'h10);
        send("R4 frm 110",      0, 10'd127, 24'h800000, 3'b000, SP_NO, 3'b111, 3'b110, 32'h7FC00000, 5'h10);
        send("R4 frm 111",      0, 10'd127, 24'h800000, 3'b000, SP_NO, 3'b111, 3'b111, 32'h7FC00000, 5'h10);
        idle(2);
        @(negedge clk);
        check("R1 idle valid low", 32'(out_valid), 32'h0);
        check("R1 idle result held", out_res, 32'h7FC00000);

        // R6 overflow
        send("R6 rne inf",      0, 10'd255, 24'h800000, 3'b000, SP_NO, 3'b000, 3'b000, 32'h7F800000, 5'h05);
        send("R6 rtz max",      0, 10'd255, 24'h800000, 3'b000, SP_NO, 3'b001, 3'b000, 32'h7F7FFFFF, 5'h05);
        send("R6 rdn pos max",  0, 10'd255, 24'h800000, 3'b000, SP_NO, 3'b010, 3'b000, 32'h7F7FFFFF, 5'h05);
        send("R6 rdn neg inf",  1, 10'd255, 24'h800000, 3'b000, SP_NO, 3'b010, 3'b000, 32'hFF800000, 5'h05);
        send("R6 rup neg max",  1, 10'd300, 24'h800000, 3'b000, SP_NO, 3'b011, 3'b000, 32'hFF7FFFFF, 5'h05);
        send("R6 rmm inf",      1, 10'd255, 24'h800000, 3'b000, SP_NO, 3'b100, 3'b000, 32'hFF800000, 5'h05);
        send("R6 carry to max", 0, 10'd254, 24'hFFFFFF, 3'b100, SP_NO, 3'b000, 3'b000, 32'h7F800000, 5'h05);
        send("R6 no carry rtz", 0, 10'd254, 24'hFFFFFF, 3'b100, SP_NO, 3'b001, 3'b000, 32'h7F7FFFFF, 5'h01);

        // R7 and R8 subnormal range
        send("R7 exact subnorm", 0, 10'd0,   24'h800000, 3'b000, SP_NO, 3'b000, 3'b000, 32'h00400000, 5'h00);
        send("R8 inexact tiny",  0, 10'h3FF, 24'h800001, 3'b000, SP_NO, 3'b000, 3'b000, 32'h00200000, 5'h03);
        send("R8 round to norm", 0, 10'd0,   24'hFFFFFF, 3'b100, SP_NO, 3'b000, 3'b000, 32'h00800000, 5'h01);
        send("R8 rtz stays tiny",0, 10'd0,   24'hFFFFFF, 3'b100, SP_NO, 3'b001, 3'b000, 32'h007FFFFF, 5'h03);
        send("R7 deep rup",      0, 10'h3D8, 24'h800000, 3'b000, SP_NO, 3'b011, 3'b000, 32'h00000001, 5'h03);
        send("R7 deep rne",      1, 10'h3D8, 24'h800000, 3'b000, SP_NO, 3'b000, 3'b000, 32'h80000000, 5'h03);

        // R9 special markers and their priority
        send("R9 invalid",      0, 10'd127, 24'h0, 3'b111, SP_INV | SP_NAN, 3'b000, 3'b000, 32'h7FC00000, 5'h10);
        send("R9 nan",          1, 10'd127, 24'h0, 3'b111, SP_NAN | SP_INF, 3'b000, 3'b000, 32'h7FC00000, 5'h00);
        send("R9 divzero",      1, 10'd0,   24'h0, 3'b000, SP_DZ | SP_INF,  3'b000, 3'b000, 32'hFF800000, 5'h08);
        send("R9 inf",          0, 10'd0,   24'h0, 3'b111, SP_INF | SP_ZERO,3'b000, 3'b000, 32'h7F800000, 5'h00);
        send("R9 zero",         1, 10'd0,   24'h0, 3'b111, SP_ZERO,         3'b000, 3'b000, 32'h80000000, 5'h00);
        idle(4);

        check("R1 queue drained", 32'(q.size()), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule